// File: doc/BRIEF.md
# Dual-Channel Timed Sine Stimulus Source

This block generates two independent streams of signed sine samples, one per output channel, meant for a digital-to-analog converter that steers a current source. Each channel has its own frequency, peak amplitude, starting phase, start delay and burst length. A shared start pulse captures every channel's settings at once. Each channel then waits for its own delay, plays a sine burst for its own length, and returns to the zero code. A shared stop pulse returns both channels to idle.

Frequency is given in whole hertz. A 32-bit phase accumulator per channel turns it into a per-cycle phase step. The starting phase is a 12-bit offset added to the top of the accumulator. A 1024-point sine, built from a stored quarter wave, supplies the waveform. Amplitude is a code from 0 to 20 and scales the sine by code/20. Delay and length are counted in seconds using one tick generator shared by both channels. The tick generator restarts on every start pulse, so all channel timing stays aligned to that pulse.

Top module: `stim_dual_gen`

## Requirements
- R1: While reset is held and immediately after it is released, every `active_o` bit is 0 and every `sample_o` word is 0.
- R2: Each channel uses only its own configuration inputs. While one channel is playing, the other can still be waiting, and the two can have different timing and waveforms.
- R3: Call the clock edge that samples `start_i` high edge 0, and let T be `TICK_CYCLES`. A channel with delay d raises `active_o` in the value that follows edge d·T+1.
- R4: `active_o` then stays high for exactly u·T clock cycles, where u is the burst length, and falls by itself afterwards. If u is 0, the channel never becomes active.
- R5: Number the samples of a burst n = 0, 1, 2, … starting from its first active cycle. The accumulator value for sample n is n·inc mod 2^32. The table index is bits [11:2] of (accumulator bits [31:20] + phase offset) mod 4096. The table value at index i is round(32767·sin(2π·i/1024)). Positive values round half up. Negative values use the mirror of the positive result.
- R6: The phase step is inc = floor(f · M / 2^16), where M = round(2^48 / CLK_HZ) and f is the latched frequency in Hz.
- R7: Each output sample equals the table value times the amplitude code, divided by 20, truncated toward zero. The result is a 16-bit two's-complement word, so at code 10 the peak values are +16383 and −16383.
- R8: Whenever a channel's `active_o` is low, its `sample_o` is exactly 0.
- R9: A stop pulse clears both `active_o` bits in the value after the edge that samples it. No channel becomes active again until the next start pulse.
- R10: Changes to the configuration inputs after a start pulse do not alter the burst in progress. They take effect only at the next start pulse.
- R11: Settings are clamped when they are latched. Frequency is limited to the range 50 to 10000. Amplitude codes above 20 become 20. Delay is capped at 600 s and length at 3600 s.
- R12: A start pulse during a burst cancels it at once. Both outputs go low after that edge, and the new settings are then played with fresh timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse: latch all settings and restart timing |
| stop_i | input | 1 | One-cycle pulse: return both channels to idle (wins over start) |
| freq_i | input | NCH×14 | Per-channel frequency in Hz |
| amp_i | input | NCH×5 | Per-channel amplitude code, 0.1 mA per step |
| phase_i | input | NCH×12 | Per-channel starting phase, full turn = 4096 |
| delay_i | input | NCH×10 | Per-channel start delay in seconds |
| dur_i | input | NCH×12 | Per-channel burst length in seconds |
| sample_o | output | NCH×16 | Per-channel signed sample word |
| active_o | output | NCH | Per-channel burst-in-progress flag |

## Verification
Every burst is compared sample by sample against a queue that is filled from the R5 to R7 formulas. The tests mix frequencies, amplitudes and offsets, so a fault in step size, quadrant folding or phase addition shows up at a different sample index. Offsets of a quarter and three quarters of a turn at code 10 land on the exact positive and negative peaks, which separates truncation from rounding. Staggered delays, a zero length, a mid-burst stop, a mid-burst restart and out-of-range settings test the timing and clamp paths. Edits made during a burst test that the latched settings are isolated from the inputs.

// File: rtl/stim_pkg.sv
package stim_pkg;

   typedef enum logic [1:0] {
      CH_IDLE = 2'd0,
      CH_WAIT = 2'd1,
      CH_RUN  = 2'd2,
      CH_DONE = 2'd3
   } ch_state_e;

   localparam real PI_R = 3.14159265358979323846;

   // Magnitude of the sine for quarter-wave point k of qn, full scale fs.
   function automatic int quarter_sine(input int k, input int qn, input int fs);
      real ang;
      ang = PI_R * real'(k) / (2.0 * real'(qn));
      return int'($floor(real'(fs) * $sin(ang) + 0.5));
   endfunction

endpackage

// File: rtl/stim_tick_gen.sv
module stim_tick_gen #(
   parameter int TICK_CYCLES = 50_000_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic restart_i,
   output logic tick_o
);
   localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

   logic [TW-1:0] cnt_q;

   assign tick_o = (cnt_q == TW'(TICK_CYCLES - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   cnt_q <= '0;
      else if (restart_i || tick_o)  cnt_q <= '0;
      else                           cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/stim_sine_rom.sv
module stim_sine_rom #(
   parameter int ADDR_W = 10,
   parameter int SAMP_W = 16
) (
   input  logic        [ADDR_W-1:0] idx_i,
   output logic signed [SAMP_W-1:0] val_o
);
   localparam int QN = 2 ** (ADDR_W - 2);
   localparam int FS = 2 ** (SAMP_W - 1) - 1;

   logic [SAMP_W-2:0] qtab [0:QN];

   for (genvar k = 0; k <= QN; k++) begin : g_tab
      assign qtab[k] = (SAMP_W-1)'(stim_pkg::quarter_sine(k, QN, FS));
   end

   logic [1:0]        quad;
   logic [ADDR_W-3:0] kpos;
   logic [ADDR_W-2:0] addr;
   logic [SAMP_W-2:0] mag;

   always_comb begin
      quad = idx_i[ADDR_W-1 -: 2];
      kpos = idx_i[ADDR_W-3:0];
      addr = quad[0] ? ((ADDR_W-1)'(QN) - {1'b0, kpos}) : {1'b0, kpos};
      mag  = qtab[addr];
      val_o = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
   end

endmodule

// File: rtl/stim_cfg_clamp.sv
module stim_cfg_clamp #(
   parameter int FREQ_W   = 14,
   parameter int AMP_W    = 5,
   parameter int DLY_W    = 10,
   parameter int DUR_W    = 12,
   parameter int FREQ_MIN = 50,
   parameter int FREQ_MAX = 10_000,
   parameter int AMP_MAX  = 20,
   parameter int DLY_MAX  = 600,
   parameter int DUR_MAX  = 3600
) (
   input  logic [FREQ_W-1:0] freq_i,
   input  logic [AMP_W-1:0]  amp_i,
   input  logic [DLY_W-1:0]  dly_i,
   input  logic [DUR_W-1:0]  dur_i,
   output logic [FREQ_W-1:0] freq_o,
   output logic [AMP_W-1:0]  amp_o,
   output logic [DLY_W-1:0]  dly_o,
   output logic [DUR_W-1:0]  dur_o
);
   always_comb begin
      if (freq_i < FREQ_W'(FREQ_MIN))       freq_o = FREQ_W'(FREQ_MIN);
      else if (freq_i > FREQ_W'(FREQ_MAX))  freq_o = FREQ_W'(FREQ_MAX);
      else                                  freq_o = freq_i;
      amp_o = (amp_i > AMP_W'(AMP_MAX)) ? AMP_W'(AMP_MAX) : amp_i;
      dly_o = (dly_i > DLY_W'(DLY_MAX)) ? DLY_W'(DLY_MAX) : dly_i;
      dur_o = (dur_i > DUR_W'(DUR_MAX)) ? DUR_W'(DUR_MAX) : dur_i;
   end

endmodule

// File: rtl/stim_chan.sv
module stim_chan
   import stim_pkg::*;
#(
   parameter int CLK_HZ   = 50_000_000,
   parameter int ACC_W    = 32,
   parameter int PH_W     = 12,
   parameter int ADDR_W   = 10,
   parameter int SAMP_W   = 16,
   parameter int FREQ_W   = 14,
   parameter int AMP_W    = 5,
   parameter int DLY_W    = 10,
   parameter int DUR_W    = 12,
   parameter int FREQ_MIN = 50,
   parameter int FREQ_MAX = 10_000,
   parameter int AMP_MAX  = 20,
   parameter int DLY_MAX  = 600,
   parameter int DUR_MAX  = 3600
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              tick_i,
   input  logic [FREQ_W-1:0] freq_i,
   input  logic [AMP_W-1:0]  amp_i,
   input  logic [PH_W-1:0]   phase_i,
   input  logic [DLY_W-1:0]  dly_i,
   input  logic [DUR_W-1:0]  dur_i,
   output logic [SAMP_W-1:0] sample_o,
   output logic              active_o
);
   localparam int          INC_FRAC = 16;
   localparam logic [63:0] INC_MULT = ((64'd1 << (ACC_W + INC_FRAC)) + 64'(CLK_HZ / 2))
                                      / 64'(CLK_HZ);
   localparam int LIM = (DLY_MAX > DUR_MAX) ? DLY_MAX : DUR_MAX;
   localparam int CW  = $clog2(LIM + 1);
   localparam int PW  = SAMP_W + AMP_W + 1;

   // clamped settings
   logic [FREQ_W-1:0] freq_c;
   logic [AMP_W-1:0]  amp_c;
   logic [DLY_W-1:0]  dly_c;
   logic [DUR_W-1:0]  dur_c;

   stim_cfg_clamp #(
      .FREQ_W(FREQ_W), .AMP_W(AMP_W), .DLY_W(DLY_W), .DUR_W(DUR_W),
      .FREQ_MIN(FREQ_MIN), .FREQ_MAX(FREQ_MAX), .AMP_MAX(AMP_MAX),
      .DLY_MAX(DLY_MAX), .DUR_MAX(DUR_MAX)
   ) u_clamp (
      .freq_i(freq_i), .amp_i(amp_i), .dly_i(dly_i), .dur_i(dur_i),
      .freq_o(freq_c), .amp_o(amp_c), .dly_o(dly_c), .dur_o(dur_c)
   );

   // latched settings
   logic [FREQ_W-1:0] freq_q;
   logic [ACC_W-1:0]  inc_q;
   logic [AMP_W-1:0]  amp_q;
   logic [PH_W-1:0]   ph_q;
   logic [DLY_W-1:0]  dly_q;
   logic [DUR_W-1:0]  dur_q;

   ch_state_e         state_q;
   logic [CW-1:0]     cnt_q;
   logic [CW-1:0]     cnt_nxt;
   logic [ACC_W-1:0]  acc_q;

   assign cnt_nxt = cnt_q + 1'b1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         freq_q  <= '0;
         inc_q   <= '0;
         amp_q   <= '0;
         ph_q    <= '0;
         dly_q   <= '0;
         dur_q   <= '0;
         state_q <= CH_IDLE;
         cnt_q   <= '0;
         acc_q   <= '0;
      end else if (stop_i) begin
         state_q <= CH_IDLE;
         cnt_q   <= '0;
      end else if (start_i) begin
         freq_q <= freq_c;
         inc_q  <= ACC_W'((64'(freq_c) * INC_MULT) >> INC_FRAC);
         amp_q  <= amp_c;
         ph_q   <= phase_i;
         dly_q  <= dly_c;
         dur_q  <= dur_c;
         cnt_q  <= '0;
         acc_q  <= '0;
         if (dly_c != '0)       state_q <= CH_WAIT;
         else if (dur_c != '0)  state_q <= CH_RUN;
         else                   state_q <= CH_DONE;
      end else begin
         unique case (state_q)
            CH_WAIT: if (tick_i) begin
               if (cnt_nxt == CW'(dly_q)) begin
                  cnt_q   <= '0;
                  acc_q   <= '0;
                  state_q <= (dur_q != '0) ? CH_RUN : CH_DONE;
               end else begin
                  cnt_q <= cnt_nxt;
               end
            end
            CH_RUN: begin
               acc_q <= acc_q + inc_q;
               if (tick_i) begin
                  if (cnt_nxt == CW'(dur_q)) begin
                     cnt_q   <= '0;
                     state_q <= CH_DONE;
                  end else begin
                     cnt_q <= cnt_nxt;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // waveform path
   logic [ADDR_W-1:0]        idx;
   logic signed [SAMP_W-1:0] sine_val;
   logic signed [PW-1:0]     prod;
   logic signed [PW-1:0]     quot;

   assign idx = ADDR_W'((acc_q[ACC_W-1 -: PH_W] + ph_q) >> (PH_W - ADDR_W));

   stim_sine_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_rom (
      .idx_i(idx),
      .val_o(sine_val)
   );

   always_comb begin
      prod = PW'(sine_val) * PW'($signed({1'b0, amp_q}));
      quot = prod / PW'(AMP_MAX);
   end

   logic              active_q;
   logic [SAMP_W-1:0] sample_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_q <= 1'b0;
         sample_q <= '0;
      end else if (stop_i || start_i) begin
         active_q <= 1'b0;
         sample_q <= '0;
      end else begin
         active_q <= (state_q == CH_RUN);
         sample_q <= (state_q == CH_RUN) ? quot[SAMP_W-1:0] : '0;
      end
   end

   assign active_o = active_q;
   assign sample_o = sample_q;

   AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == CH_WAIT) |-> (cnt_q < CW'(dly_q)));                       // R3
   AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == CH_RUN) |-> (cnt_q < CW'(dur_q)));                        // R4
   AST_BURST_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(state_q == CH_RUN) |-> (acc_q == '0));                          // R5
   AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> $stable({freq_q, inc_q, amp_q, ph_q, dly_q, dur_q}));    // R10
   AST_CFG_LIMITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != CH_IDLE) |-> (amp_q <= AMP_W'(AMP_MAX) &&
                                freq_q >= FREQ_W'(FREQ_MIN) &&
                                freq_q <= FREQ_W'(FREQ_MAX)));              // R11

endmodule

// File: rtl/stim_dual_gen.sv
module stim_dual_gen #(
   parameter int NCH         = 2,
   parameter int CLK_HZ      = 50_000_000,
   parameter int TICK_CYCLES = CLK_HZ,
   parameter int ACC_W       = 32,
   parameter int PH_W        = 12,
   parameter int ADDR_W      = 10,
   parameter int SAMP_W      = 16,
   parameter int FREQ_W      = 14,
   parameter int AMP_W       = 5,
   parameter int DLY_W       = 10,
   parameter int DUR_W       = 12,
   parameter int FREQ_MIN    = 50,
   parameter int FREQ_MAX    = 10_000,
   parameter int AMP_MAX     = 20,
   parameter int DLY_MAX     = 600,
   parameter int DUR_MAX     = 3600
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        start_i,
   input  logic                        stop_i,
   input  logic [NCH-1:0][FREQ_W-1:0]  freq_i,
   input  logic [NCH-1:0][AMP_W-1:0]   amp_i,
   input  logic [NCH-1:0][PH_W-1:0]    phase_i,
   input  logic [NCH-1:0][DLY_W-1:0]   delay_i,
   input  logic [NCH-1:0][DUR_W-1:0]   dur_i,
   output logic [NCH-1:0][SAMP_W-1:0]  sample_o,
   output logic [NCH-1:0]              active_o
);
   // elaboration-time parameter checks
   if (NCH < 1) begin : g_chk_nch
      $error("NCH must be at least 1");
   end
   if (ADDR_W < 3 || PH_W < ADDR_W || ACC_W < PH_W) begin : g_chk_phase
      $error("phase widths must satisfy 3 <= ADDR_W <= PH_W <= ACC_W");
   end
   if (TICK_CYCLES < 1 || CLK_HZ < 1) begin : g_chk_clk
      $error("clock and tick settings must be positive");
   end
   if (FREQ_MIN > FREQ_MAX || FREQ_MAX >= 2 ** FREQ_W) begin : g_chk_freq
      $error("frequency limits do not fit FREQ_W");
   end
   if (AMP_MAX < 1 || AMP_MAX >= 2 ** AMP_W) begin : g_chk_amp
      $error("amplitude limit does not fit AMP_W");
   end
   if (DLY_MAX >= 2 ** DLY_W || DUR_MAX >= 2 ** DUR_W) begin : g_chk_time
      $error("delay or length limit does not fit its field");
   end

   logic tick;

   stim_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .restart_i(start_i),
      .tick_o   (tick)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      stim_chan #(
         .CLK_HZ(CLK_HZ), .ACC_W(ACC_W), .PH_W(PH_W), .ADDR_W(ADDR_W),
         .SAMP_W(SAMP_W), .FREQ_W(FREQ_W), .AMP_W(AMP_W), .DLY_W(DLY_W),
         .DUR_W(DUR_W), .FREQ_MIN(FREQ_MIN), .FREQ_MAX(FREQ_MAX),
         .AMP_MAX(AMP_MAX), .DLY_MAX(DLY_MAX), .DUR_MAX(DUR_MAX)
      ) u_chan (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .start_i (start_i),
         .stop_i  (stop_i),
         .tick_i  (tick),
         .freq_i  (freq_i[g]),
         .amp_i   (amp_i[g]),
         .phase_i (phase_i[g]),
         .dly_i   (delay_i[g]),
         .dur_i   (dur_i[g]),
         .sample_o(sample_o[g]),
         .active_o(active_o[g])
      );

      AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !active_o[g] |-> (sample_o[g] == '0));                            // R8
   end

   AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> (active_o == '0));                                          // R9
   AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (active_o == '0));                                         // R12

endmodule

// File: tb/stim_dual_gen_tb.sv
module stim_dual_gen_tb;
   localparam int  T      = 100;
   localparam int  CLKHZ  = 1_000_000;
   localparam real PI_B   = 3.14159265358979323846;
   localparam longint unsigned MULT = ((64'd1 << 48) + 64'(CLKHZ / 2)) / 64'(CLKHZ);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic stop = 1'b0;
   logic [1:0][13:0] freq  = '0;
   logic [1:0][4:0]  amp   = '0;
   logic [1:0][11:0] phase = '0;
   logic [1:0][9:0]  dly   = '0;
   logic [1:0][11:0] dur   = '0;
   logic [1:0][15:0] sample;
   logic [1:0]       active;

   always #2.5 clk = ~clk;

   stim_dual_gen #(.CLK_HZ(CLKHZ), .TICK_CYCLES(T)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
      .freq_i(freq), .amp_i(amp), .phase_i(phase), .delay_i(dly), .dur_i(dur),
      .sample_o(sample), .active_o(active)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;
   string cur_tag = "init";

   int q0[$];
   int q1[$];
   int exp_rise [2];
   int exp_len  [2];
   int len      [2];
   int first_s  [2];
   int rises    [2];
   bit skip_len [2];
   bit prev_act [2];
   int cyc = 0;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s [%s]: actual %0d expected %0d", req, cur_tag, act, exp);
      end
   endtask

   function automatic int exp_sample(input longint unsigned inc, input int a,
                                     input int ph, input int n);
      longint unsigned acc;
      int p, idx, s;
      real v;
      acc = (longint'(n) * inc) & 64'hFFFF_FFFF;
      p   = int'(((acc >> 20) + longint'(ph)) & 64'hFFF);
      idx = p >> 2;
      v   = 32767.0 * $sin(2.0 * PI_B * real'(idx) / 1024.0);
      if (v >= 0.0) s = int'($floor(v + 0.5));
      else          s = -int'($floor(-v + 0.5));
      return (s * a) / 20;
   endfunction

   // bench-side clamping and queue fill for one channel
   task automatic expect_ch(input int ch, input int f, input int a, input int p,
                            input int d, input int u);
      longint unsigned inc;
      int fc, ac, dc, uc;
      fc = (f < 50) ? 50 : ((f > 10000) ? 10000 : f);
      ac = (a > 20) ? 20 : a;
      dc = (d > 600) ? 600 : d;
      uc = (u > 3600) ? 3600 : u;
      inc = (longint'(fc) * MULT) >> 16;
      exp_rise[ch] = (uc == 0) ? -1 : dc * T + 1;
      exp_len[ch]  = uc * T;
      if (ch == 0) q0.delete(); else q1.delete();
      for (int n = 0; n < uc * T; n++) begin
         if (ch == 0) q0.push_back(exp_sample(inc, ac, p, n));
         else         q1.push_back(exp_sample(inc, ac, p, n));
      end
   endtask

   task automatic start_burst(input int f0, input int a0, input int p0, input int d0, input int u0,
                              input int f1, input int a1, input int p1, input int d1, input int u1);
      freq[0] = 14'(f0); amp[0] = 5'(a0); phase[0] = 12'(p0); dly[0] = 10'(d0); dur[0] = 12'(u0);
      freq[1] = 14'(f1); amp[1] = 5'(a1); phase[1] = 12'(p1); dly[1] = 10'(d1); dur[1] = 12'(u1);
      for (int ch = 0; ch < 2; ch++) begin
         skip_len[ch] = active[ch];
         exp_rise[ch] = -1;
      end
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      expect_ch(0, f0, a0, p0, d0, u0);
      expect_ch(1, f1, a1, p1, d1, u1);
      rises[0] = 0; rises[1] = 0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic at_cyc(input int k);
      do @(negedge clk); while (cyc != k);
   endtask

   always @(posedge clk) begin
      if (start) cyc <= 0;
      else       cyc <= cyc + 1;
   end

   // monitor: pops expected samples and compares
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         for (int ch = 0; ch < 2; ch++) begin
            int s;
            int e;
            bit a;
            a = active[ch];
            s = int'($signed(sample[ch]));
            if (a && !prev_act[ch]) begin
               rises[ch]++;
               check("R3 rise cycle", cyc, exp_rise[ch]);
               first_s[ch] = s;
               len[ch] = 0;
            end
            if (a) begin
               len[ch]++;
               if ((ch == 0 && q0.size() == 0) || (ch == 1 && q1.size() == 0)) begin
                  check("R4 sample beyond burst", len[ch], exp_len[ch]);
               end else begin
                  e = (ch == 0) ? q0.pop_front() : q1.pop_front();
                  check("R5/R6 sample value", s, e);
               end
            end
            if (!a && prev_act[ch]) begin
               if (!skip_len[ch]) check("R4 burst length", len[ch], exp_len[ch]);
               skip_len[ch] = 1'b0;
            end
            if (!a) check("R8 idle sample", s, 0);
            prev_act[ch] = a;
         end
      end
   end

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int ch = 0; ch < 2; ch++) begin
         exp_rise[ch] = -1; exp_len[ch] = 0; len[ch] = 0;
         skip_len[ch] = 0; prev_act[ch] = 0; rises[ch] = 0; first_s[ch] = 0;
      end
      repeat (3) @(negedge clk);
      cur_tag = "reset";
      check("R1 active in reset", int'(active), 0);
      check("R1 sample in reset", int'(sample[0] | sample[1]), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 active after reset", int'(active), 0);
      check("R1 sample after reset", int'(sample[0] | sample[1]), 0);
      @(posedge clk); #1;

      // staggered independent channels
      cur_tag = "R2 independent";
      start_burst(1000, 20, 12'h400, 1, 2,   2500, 7, 12'h000, 3, 1);
      at_cyc(150);
      check("R2 ch0 active", int'(active[0]), 1);
      check("R2 ch1 waiting", int'(active[1]), 0);
      at_cyc(450);
      check("R4 ch0 queue drained", q0.size(), 0);
      check("R4 ch1 queue drained", q1.size(), 0);
      @(posedge clk); #1;

      // exact peaks at code 10
      cur_tag = "R7 truncation";
      start_burst(50, 10, 12'h400, 0, 1,   50, 10, 12'hC00, 0, 1);
      at_cyc(150);
      check("R7 positive peak", first_s[0], 16383);
      check("R7 negative peak", first_s[1], -16383);
      @(posedge clk); #1;

      // inputs edited during a burst
      cur_tag = "R10 edits ignored";
      start_burst(3000, 15, 12'h200, 1, 2,   777, 20, 12'h100, 0, 3);
      wait_cyc(50);
      for (int ch = 0; ch < 2; ch++) begin
         freq[ch] = 14'd9000; amp[ch] = 5'd3; phase[ch] = '0; dly[ch] = '0; dur[ch] = 12'd1;
      end
      at_cyc(350);
      check("R10 ch0 burst complete", q0.size(), 0);
      check("R10 ch1 burst complete", q1.size(), 0);
      @(posedge clk); #1;

      // stop in the middle of a burst
      cur_tag = "R9 stop";
      start_burst(400, 20, 12'h000, 0, 5,   600, 12, 12'h080, 2, 5);
      wait_cyc(250);
      for (int ch = 0; ch < 2; ch++) begin
         skip_len[ch] = active[ch];
         exp_rise[ch] = -1;
      end
      stop = 1'b1;
      @(posedge clk); #1;
      stop = 1'b0;
      q0.delete(); q1.delete();
      rises[0] = 0; rises[1] = 0;
      @(negedge clk);
      check("R9 active cleared", int'(active), 0);
      wait_cyc(800);
      check("R9 no restart ch0", rises[0], 0);
      check("R9 no restart ch1", rises[1], 0);

      // restart while running
      cur_tag = "R12 restart";
      start_burst(100, 20, 12'h000, 0, 3,   200, 18, 12'h300, 1, 3);
      wait_cyc(120);
      start_burst(5000, 9, 12'h600, 1, 1,   8000, 20, 12'h000, 0, 1);
      @(negedge clk);
      check("R12 outputs cleared", int'(active), 0);
      at_cyc(300);
      check("R12 ch0 new burst seen", rises[0], 1);
      check("R12 ch1 new burst seen", rises[1], 1);
      @(posedge clk); #1;

      // zero length
      cur_tag = "R4 zero length";
      start_burst(1000, 20, 12'h000, 2, 0,   1000, 20, 12'h000, 0, 0);
      at_cyc(400);
      check("R4 zero length ch0 silent", rises[0], 0);
      check("R4 zero length ch1 silent", rises[1], 0);
      @(posedge clk); #1;

      // clamping of out-of-range settings
      cur_tag = "R11 clamp";
      start_burst(5, 31, 12'h000, 1023, 1,   16383, 25, 12'h300, 0, 1);
      at_cyc(300);
      check("R11 ch1 burst at clamped freq", q1.size(), 0);
      at_cyc(60200);
      check("R11 ch0 rise after clamped delay", rises[0], 1);
      check("R11 ch0 burst at clamped amp", q0.size(), 0);

      finish_run();
   end

endmodule